// File: doc/BRIEF.md
# Descriptor Ring Fetch Engine

This block walks a circular list of two-word descriptors kept in host memory on behalf of one DMA channel. Each entry holds a control/length word followed by a 32-bit buffer pointer. The engine reads the entry at its current position. If the host has marked the entry as owned by hardware, the engine passes the buffer pointer, the byte count and the end-of-packet flag to a downstream data mover over a valid/ready channel. When the mover reports completion, the engine writes the control word back with the ownership bit cleared, raises an optional done pulse, and steps to the next entry. A jump entry redirects the position to an arbitrary address, and this is how the ring wraps. An entry not owned by hardware is re-read after a programmable wait while polling is enabled.

All host memory traffic goes through one request/response port, with at most one read in flight. A request (`mem_req_valid`) holds its address, direction and write data unchanged until `mem_req_ready` is seen high at a clock edge. A read response is a single cycle of `mem_rsp_valid` and cannot be stalled. Writes get no response. On the mover side, `xfer_valid` holds its payload steady until `xfer_ready` is taken. The mover then signals the end of its work with a single-cycle `xfer_done` pulse. The engine keeps exactly one transfer outstanding.

Top module: `ring_walker`

## Requirements
- R1: Reset drives `mem_req_valid`, `xfer_valid` and `done_evt` low, and it places the fetch position at address 0. No memory request is made while `poll_en` is low and the engine is idle.
- R2: An entry is fetched as a read of its control word at the position, then (if owned) a read of its pointer at position+4. A memory request and a transfer offer are never active in the same cycle.
- R3: An owned data entry (bit 31 = 1, bit 30 = 0) is offered to the mover with `xfer_addr` = pointer word, `xfer_len` = control bits 15:0 and `xfer_last` = control bit 29. The offer holds steady until `xfer_ready`.
- R4: After `xfer_done`, the engine writes the control word back to the entry's address with bit 31 cleared and every other bit unchanged. The position then advances by 8 bytes.
- R5: When control bit 25 of a completed entry is set, `done_evt` pulses high for one cycle right after the write-back is accepted. Otherwise it stays low.
- R6: An owned jump entry (bits 31 and 30 set) loads the position from its pointer word. It is neither offered to the mover nor written back.
- R7: An entry with bit 31 clear, jump or not, produces no transfer. With `poll_en` high, the engine re-reads the same control word. Its read request is raised D clock edges after the edge that took the non-owned response, where D = (`poll_freq`+1) << `poll_scale`.
- R8: If `poll_en` is low when a non-owned entry is seen, the engine goes idle and issues no further memory requests.
- R9: A cycle with `base_we` high loads the position from `base_addr` and returns the engine to idle. The next fetch (once `poll_en` is high) reads `base_addr`.
- R10: A memory request not yet accepted keeps `mem_req_valid`, `mem_req_addr`, `mem_req_write` and `mem_req_wdata` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load ring start address and go idle |
| base_addr | input | ADDR_W | Ring start byte address |
| poll_en | input | 1 | Allow fetching and re-polling |
| poll_freq | input | FREQ_W | Poll wait base count minus one |
| poll_scale | input | SCALE_W | Poll wait left shift |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data present (one cycle) |
| mem_rsp_data | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer offered to mover |
| xfer_ready | input | 1 | Mover takes the transfer |
| xfer_addr | output | 32 | Buffer pointer |
| xfer_len | output | LEN_W | Buffer byte count |
| xfer_last | output | 1 | End of packet |
| xfer_done | input | 1 | Mover finished (one-cycle pulse) |
| done_evt | output | 1 | Per-entry done pulse |

## Verification
The hardest state to reach is a non-owned jump entry. It only shows up after a data entry has been consumed, and the only sign of it at the ports is repeated reads of one address with no transfer offered. The bench builds a second ring whose jump entry is left unowned, counts reads of that address while confirming the mover sees nothing, and then marks the entry owned to see the redirect taken. Exact poll timing is measured with random back-pressure and latency switched off, so that the gap between reads depends only on the programmed wait.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;
  localparam int WORD_W    = 32;
  localparam int OWN_BIT   = 31;
  localparam int JUMP_BIT  = 30;
  localparam int LAST_BIT  = 29;
  localparam int EVT_BIT   = 25;
  localparam int ENTRY_B   = 8;
  localparam int PTR_OFS   = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEN_REQ,
    ST_LEN_WAIT,
    ST_PTR_REQ,
    ST_PTR_WAIT,
    ST_OFFER,
    ST_BUSY,
    ST_WBACK,
    ST_POLL
  } walk_state_t;
endpackage

// File: rtl/ring_cursor.sv
module ring_cursor #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_base,
  input  logic [ADDR_W-1:0] base,
  input  logic              load_jump,
  input  logic [ADDR_W-1:0] jump_to,
  input  logic              advance,
  output logic [ADDR_W-1:0] pos
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos <= '0;
    else if (load_base) pos <= base;
    else if (load_jump) pos <= jump_to;
    else if (advance)   pos <= pos + STEP_V;
  end
endmodule

// File: rtl/ring_poll_timer.sv
module ring_poll_timer #(
  parameter int FREQ_W  = 4,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FREQ_W-1:0]  freq,
  input  logic [SCALE_W-1:0] scale,
  output logic               expire
);
  localparam int TMR_W = FREQ_W + (1 << SCALE_W);

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] span;

  always_comb span = (TMR_W'(freq) + TMR_W'(1)) << scale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= span;
    else if (cnt != '0)    cnt <= cnt - TMR_W'(1);
  end

  assign expire = (cnt == TMR_W'(1));
endmodule

// File: rtl/ring_desc_latch.sv
module ring_desc_latch
  import ring_walk_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ctl,
  input  logic              cap_ptr,
  input  logic [WORD_W-1:0] rsp,
  output logic [WORD_W-1:0] ctl_word,
  output logic [WORD_W-1:0] ptr_word,
  output logic              is_jump,
  output logic              is_last,
  output logic              want_evt,
  output logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] ctl_back
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_word <= '0;
      ptr_word <= '0;
    end else begin
      if (cap_ctl) ctl_word <= rsp;
      if (cap_ptr) ptr_word <= rsp;
    end
  end

  always_comb begin
    is_jump  = ctl_word[JUMP_BIT];
    is_last  = ctl_word[LAST_BIT];
    want_evt = ctl_word[EVT_BIT];
    len      = ctl_word[LEN_W-1:0];
    ctl_back = ctl_word;
    ctl_back[OWN_BIT] = 1'b0;
  end
endmodule

// File: rtl/ring_walker.sv
module ring_walker
  import ring_walk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int FREQ_W  = 4,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_we,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic               poll_en,
  input  logic [FREQ_W-1:0]  poll_freq,
  input  logic [SCALE_W-1:0] poll_scale,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [31:0]        mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [31:0]        xfer_addr,
  output logic [LEN_W-1:0]   xfer_len,
  output logic               xfer_last,
  input  logic               xfer_done,
  output logic               done_evt
);
  localparam logic [ADDR_W-1:0] PTR_OFS_V = ADDR_W'(PTR_OFS);

  walk_state_t       state;
  logic [ADDR_W-1:0] pos;
  logic [31:0]       ctl_word, ptr_word, ctl_back;
  logic              is_jump, is_last, want_evt;
  logic [LEN_W-1:0]  len;
  logic              cap_ctl, cap_ptr, owned_rsp;
  logic              tmr_start, tmr_expire;
  logic              take_jump, step_fwd;

  always_comb begin
    owned_rsp = mem_rsp_data[OWN_BIT];
    cap_ctl   = (state == ST_LEN_WAIT) && mem_rsp_valid;
    cap_ptr   = (state == ST_PTR_WAIT) && mem_rsp_valid;
    tmr_start = cap_ctl && !owned_rsp && poll_en;
    take_jump = cap_ptr && is_jump;
    step_fwd  = (state == ST_WBACK) && mem_req_ready;
  end

  ring_cursor #(.ADDR_W(ADDR_W), .STEP(ENTRY_B)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_base(base_we),
    .base     (base_addr),
    .load_jump(take_jump),
    .jump_to  (ptr_word_next()),
    .advance  (step_fwd),
    .pos      (pos)
  );

  function automatic logic [ADDR_W-1:0] ptr_word_next();
    return mem_rsp_data[ADDR_W-1:0];
  endfunction

  ring_poll_timer #(.FREQ_W(FREQ_W), .SCALE_W(SCALE_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .freq  (poll_freq),
    .scale (poll_scale),
    .expire(tmr_expire)
  );

  ring_desc_latch #(.LEN_W(LEN_W)) u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_ctl (cap_ctl),
    .cap_ptr (cap_ptr),
    .rsp     (mem_rsp_data),
    .ctl_word(ctl_word),
    .ptr_word(ptr_word),
    .is_jump (is_jump),
    .is_last (is_last),
    .want_evt(want_evt),
    .len     (len),
    .ctl_back(ctl_back)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      done_evt <= 1'b0;
    end else begin
      done_evt <= 1'b0;
      if (base_we) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE:     if (poll_en) state <= ST_LEN_REQ;
          ST_LEN_REQ:  if (mem_req_ready) state <= ST_LEN_WAIT;
          ST_LEN_WAIT: if (mem_rsp_valid) begin
                         if (owned_rsp)    state <= ST_PTR_REQ;
                         else if (poll_en) state <= ST_POLL;
                         else              state <= ST_IDLE;
                       end
          ST_PTR_REQ:  if (mem_req_ready) state <= ST_PTR_WAIT;
          ST_PTR_WAIT: if (mem_rsp_valid) state <= is_jump ? ST_LEN_REQ : ST_OFFER;
          ST_OFFER:    if (xfer_ready) state <= ST_BUSY;
          ST_BUSY:     if (xfer_done) state <= ST_WBACK;
          ST_WBACK:    if (mem_req_ready) begin
                         state    <= ST_LEN_REQ;
                         done_evt <= want_evt;
                       end
          ST_POLL:     if (tmr_expire) state <= ST_LEN_REQ;
          default:     state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    mem_req_valid = (state == ST_LEN_REQ) || (state == ST_PTR_REQ) || (state == ST_WBACK);
    mem_req_write = (state == ST_WBACK);
    mem_req_addr  = (state == ST_PTR_REQ) ? pos + PTR_OFS_V : pos;
    mem_req_wdata = (state == ST_WBACK) ? ctl_back : '0;
    xfer_valid    = (state == ST_OFFER);
    xfer_addr     = ptr_word;
    xfer_len      = len;
    xfer_last     = is_last;
  end
endmodule

// File: rtl/ring_walker_checker.sv
module ring_walker_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [31:0]       xfer_addr,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              xfer_last,
  input logic              done_evt
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  assert_offer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr)
      && $stable(xfer_len) && $stable(xfer_last));

  assert_one_at_a_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && xfer_valid));

  assert_wback_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> !mem_req_wdata[31] && (mem_req_addr[2:0] == 3'd0));

  assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);

  assert_evt_after_wback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_evt) |-> $past(mem_req_valid && mem_req_write && mem_req_ready));
endmodule

bind ring_walker ring_walker_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_ring_walker.sv
module test_ring_walker;
  localparam int ADDR_W = 32, LEN_W = 16, FREQ_W = 4, SCALE_W = 4;

  logic clk = 0, rst_n = 0;
  logic base_we = 0, poll_en = 0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [FREQ_W-1:0] poll_freq = '0;
  logic [SCALE_W-1:0] poll_scale = '0;
  logic mem_req_valid, mem_req_ready = 0, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_data = '0;
  logic mem_rsp_valid = 0;
  logic xfer_valid, xfer_ready = 0, xfer_last, xfer_done = 0, done_evt;
  logic [31:0] xfer_addr;
  logic [LEN_W-1:0] xfer_len;

  always #2.5 clk = ~clk;

  ring_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FREQ_W(FREQ_W), .SCALE_W(SCALE_W)) i_ring_walker (.*);

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] mem [0:255];
  logic [31:0] e_addr [0:63];
  logic [15:0] e_len [0:63];
  logic e_last [0:63];
  int exp_n = 0, got_n = 0, exp_done = 0, done_cnt = 0;
  int rd_cnt = 0, wr_cnt = 0, watch_hits = 0, watch_prev = 0, watch_last = 0;
  logic [31:0] watch_addr = 32'h100, first_rd = '0;
  bit want_first = 0, rnd = 1;
  bit pend = 0; int lat = 0; logic [7:0] pidx = '0;
  bit busy = 0; int dcnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int poll_gap(input int f, input int s);
    return ((f + 1) << s) + 2;
  endfunction

  // memory model, acts at the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 0;
    if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid = 1; mem_rsp_data = mem[pidx]; pend = 0;
      end else lat--;
    end
    mem_req_ready = rnd ? (($urandom % 4) != 0) : 1'b1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[9:2]] = mem_req_wdata; wr_cnt++;
      end else begin
        pend = 1; pidx = mem_req_addr[9:2]; lat = rnd ? int'($urandom % 3) : 0; rd_cnt++;
        if (want_first) begin first_rd = mem_req_addr; want_first = 0; end
        if (mem_req_addr == watch_addr) begin
          watch_prev = watch_last; watch_last = cyc; watch_hits++;
        end
      end
    end
  end

  // data mover model
  always @(negedge clk) begin
    xfer_done = 0;
    if (busy) begin
      if (dcnt == 0) begin xfer_done = 1; busy = 0; end else dcnt--;
    end
    xfer_ready = !busy && (rnd ? (($urandom % 3) != 0) : 1'b1);
    if (rst_n && xfer_valid && xfer_ready) begin
      if (got_n < exp_n) begin
        chk(xfer_addr == e_addr[got_n], "R3 pointer", xfer_addr, e_addr[got_n]);
        chk(xfer_len == e_len[got_n], "R3 length", 32'(xfer_len), 32'(e_len[got_n]));
        chk(xfer_last == e_last[got_n], "R3 last flag", 32'(xfer_last), 32'(e_last[got_n]));
      end else chk(0, "R6 unexpected transfer", xfer_addr, 0);
      got_n++; busy = 1; dcnt = int'($urandom % 3);
    end
    if (done_evt) done_cnt++;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_xfers(input int target);
    for (int i = 0; i < 5000 && got_n < target; i++) @(negedge clk);
    chk(got_n == target, "R3 transfer count", got_n, target);
  endtask

  // build one data entry at word index w
  task automatic put_data(input int w);
    logic [31:0] ctl, ptr;
    ctl = 32'h8000_0000 | ($urandom & 32'h0000_ffff) | ($urandom & 32'h2200_0000) | ($urandom & 32'h00f0_0000);
    ptr = $urandom;
    mem[w + 1] = ptr; mem[w] = ctl;
    e_addr[exp_n] = ptr; e_len[exp_n] = ctl[15:0]; e_last[exp_n] = ctl[29];
    exp_n++;
    if (ctl[25]) exp_done++;
  endtask

  task automatic write_base(input logic [31:0] a);
    base_addr = a; base_we = 1; want_first = 1;
    @(negedge clk); base_we = 0;
  endtask

  logic [31:0] keep [0:4];
  int snap;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    tick(4);
    chk(mem_req_valid == 0, "R1 reset req", 32'(mem_req_valid), 0);
    chk(xfer_valid == 0, "R1 reset offer", 32'(xfer_valid), 0);
    chk(done_evt == 0, "R1 reset event", 32'(done_evt), 0);
    rst_n = 1;
    tick(20);
    chk(rd_cnt == 0, "R1 no fetch while disabled", rd_cnt, 0);

    // ring at 0x100: five data entries and a jump back
    for (int k = 0; k < 5; k++) begin put_data(64 + 2 * k); keep[k] = mem[64 + 2 * k]; end
    mem[75] = 32'h100; mem[74] = 32'hC000_0000;
    poll_freq = 1; poll_scale = 1;
    write_base(32'h100);
    poll_en = 1;
    wait_xfers(5);
    tick(80);
    chk(first_rd == 32'h100, "R9 first fetch at base", first_rd, 32'h100);
    for (int k = 0; k < 5; k++)
      chk(mem[64 + 2 * k] == (keep[k] & 32'h7fff_ffff), "R4 write-back", mem[64 + 2 * k], keep[k] & 32'h7fff_ffff);
    chk(mem[74] == 32'hC000_0000, "R6 jump entry untouched", mem[74], 32'hC000_0000);
    chk(done_cnt == exp_done, "R5 done events", done_cnt, exp_done);
    chk(watch_hits >= 3, "R7 re-poll after wrap", watch_hits, 3);

    // exact poll timing without random stalls
    rnd = 0; poll_freq = 3; poll_scale = 2;
    tick(200);
    chk(watch_last - watch_prev == poll_gap(3, 2), "R7 poll gap 16", watch_last - watch_prev, poll_gap(3, 2));
    poll_freq = 0; poll_scale = 0;
    tick(60);
    chk(watch_last - watch_prev == poll_gap(0, 0), "R7 poll gap 1", watch_last - watch_prev, poll_gap(0, 0));
    poll_freq = 2; poll_scale = 0;
    tick(60);
    chk(watch_last - watch_prev == poll_gap(2, 0), "R7 poll gap 3", watch_last - watch_prev, poll_gap(2, 0));
    rnd = 1;

    // refill the first two entries: second lap
    put_data(64); put_data(66);
    wait_xfers(7);
    tick(60);
    chk(mem[66][31] == 0, "R4 second lap cleared", mem[66], 0);

    // disable and check silence
    poll_en = 0;
    tick(100);
    snap = rd_cnt + wr_cnt;
    tick(100);
    chk(rd_cnt + wr_cnt == snap, "R8 idle after disable", rd_cnt + wr_cnt, snap);

    // second ring with an unowned jump entry
    put_data(128);
    mem[131] = 32'h300; mem[130] = 32'h4000_0000;
    put_data(192);
    mem[194] = 32'h0;
    watch_addr = 32'h208; watch_hits = 0;
    write_base(32'h200);
    tick(10);
    chk(rd_cnt + wr_cnt == snap, "R9 idle after base load", rd_cnt + wr_cnt, snap);
    poll_en = 1;
    wait_xfers(8);
    chk(first_rd == 32'h200, "R9 fetch from new base", first_rd, 32'h200);
    tick(120);
    chk(got_n == 8, "R7 unowned jump not taken", got_n, 8);
    chk(watch_hits >= 2, "R7 unowned jump polled", watch_hits, 2);
    mem[130] = 32'hC000_0000;
    wait_xfers(9);
    tick(40);
    chk(mem[130] == 32'hC000_0000, "R6 jump not written back", mem[130], 32'hC000_0000);
    chk(done_cnt == exp_done, "R5 final done events", done_cnt, exp_done);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule